// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave Controller

This block is the control logic of a 256-byte nonvolatile memory that is reached over a two-wire serial bus. It samples the bus clock and data lines on the system clock and detects bus start and stop events. It takes in a device address byte, a word address byte and a data byte, and acknowledges each accepted byte by pulling the data line low during the ninth bus clock. The data pad is open-drain, so the block has only a pull-low enable and never drives the line high.

A completed write is committed when the bus stop arrives. It then starts a self-timed programming interval whose length is set in system clock cycles. While that interval runs, the block does not acknowledge its own device address, so a master can poll with address bytes until it sees an acknowledge. Reads return bytes from a register model of the array. The first bit sent is the MSB. The word pointer advances after each byte and wraps around the end of the array.

Top module: `i2c_eeprom_ctrl`

## Requirements
- R1: After reset, and whenever the block is neither acknowledging nor sending read data, `sda_oe_o` is 0, which releases the data line.
- R2: A falling data line while the clock is high is a start, and the block then receives a device address. A rising data line while the clock is high is a stop, and the block then returns to idle.
- R3: The device address byte is sent MSB first. Its upper 7 bits are compared against `DEV_ADDR`, and bit 0 selects the direction (0 = write, 1 = read). On a match the line is pulled low during the ninth clock. On a mismatch it is left released.
- R4: A write is a device address byte with bit 0 = 0, then a word address byte, then one data byte, and each of the three is acknowledged. The data byte is stored at the word address when the stop arrives. Any further data bytes in the same transfer are not acknowledged and are discarded.
- R5: A stored write makes the block busy for `PROG_CYCLES` system clocks. During that time a matching device address is not acknowledged. Once the time has passed, it is acknowledged again.
- R6: A read sends 8 bits MSB first, starting at the current word pointer. The pointer is set by the last word address byte received. After a stored write it points to the written address + 1.
- R7: When the master acknowledges a read byte, the next byte follows from the pointer + 1. The pointer wraps from 255 to 0.
- R8: When the master does not acknowledge a read byte, the block releases the line and stays silent until the next start.
- R9: A start or stop that arrives in the middle of a byte aborts the transfer. An interrupted write stores nothing and does not make the block busy. A start that interrupts a byte begins reception of a new device address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level (wired value) |
| sda_oe_o | output | 1 | 1 pulls the data line low |

## Verification
The main write-then-read path is tried with a table of address and data pairs. The table covers both ends of the address range and the all-zero, all-one and alternating data patterns, so bit order, address decoding and stuck data bits each show up as a distinct mismatch. After each write the bench polls until it gets an acknowledge and requires at least one refused poll first, which separates a block that times its programming from one that accepts writes at once. Directed sequences then cover:
- a foreign device address;
- a second data byte in one write;
- a current-address read;
- a sequential read across the top of the array;
- a stop inside a data byte;
- a start inside an address byte.

Each of these is aimed at one ordering or abort rule.

// File: rtl/ee_ctrl_pkg.sv
package ee_ctrl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_DEV, ST_WADDR, ST_WDATA, ST_ACK, ST_RD, ST_RACK
  } ee_state_e;

  typedef enum logic [1:0] {
    NX_WADDR, NX_WDATA, NX_RD, NX_HOLD
  } ee_next_e;
endpackage

// File: rtl/ee_line_sampler.sv
module ee_line_sampler #(
  parameter int unsigned SYNC = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [SYNC-1:0] scl_sync, sda_sync;
  logic scl_q, sda_q, scl_now, sda_now;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_sync <= '1;
      sda_sync <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_sync <= {scl_sync[SYNC-2:0], scl_i};
      sda_sync <= {sda_sync[SYNC-2:0], sda_i};
      scl_q    <= scl_now;
      sda_q    <= sda_now;
    end
  end

  assign scl_now    = scl_sync[SYNC-1];
  assign sda_now    = sda_sync[SYNC-1];
  assign sda_o      = sda_now;
  assign scl_rise_o = scl_now & ~scl_q;
  assign scl_fall_o = ~scl_now & scl_q;
  // data edges only count as events while the clock stays high
  assign start_o    = scl_now & scl_q & sda_q & ~sda_now;
  assign stop_o     = scl_now & scl_q & ~sda_q & sda_now;
endmodule

// File: rtl/ee_prog_timer.sv
module ee_prog_timer #(
  parameter int unsigned CYCLES = 2500000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o
);
  localparam int CW = $clog2(CYCLES + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt <= '0;
    else if (start_i)       cnt <= CW'(CYCLES);
    else if (cnt != '0)     cnt <= cnt - 1'b1;
  end

  assign busy_o = (cnt != '0);

  // R5
  no_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !busy_o);
endmodule

// File: rtl/ee_mem_array.sv
module ee_mem_array #(
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  localparam int unsigned DEPTH = 1 << AW;
  logic [DW-1:0] cells [DEPTH];

  // nonvolatile contents: no reset
  always_ff @(posedge clk_i) begin
    if (we_i) cells[waddr_i] <= wdata_i;
  end

  assign rdata_o = cells[raddr_i];
endmodule

// File: rtl/i2c_eeprom_ctrl.sv
module i2c_eeprom_ctrl
  import ee_ctrl_pkg::*;
#(
  parameter logic [6:0]  DEV_ADDR    = 7'h50,
  parameter int unsigned PROG_CYCLES = 2500000,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe_o
);
  localparam int unsigned AW = 8;
  localparam int unsigned DW = 8;
  localparam int unsigned BW = $clog2(DW);
  localparam logic [BW-1:0] LAST_BIT = BW'(DW - 1);

  logic sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic busy, commit;
  logic [DW-1:0] mem_rdata;

  ee_state_e st;
  ee_next_e  nxt;
  logic [BW-1:0] bit_cnt;
  logic [DW-1:0] sh;
  logic          byte_rdy, pend_wr, oe_q, m_ack;
  logic [AW-1:0] ptr, wr_addr;
  logic [DW-1:0] wr_data;

  ee_line_sampler #(.SYNC(SYNC_STAGES)) u_sampler (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_det), .stop_o(stop_det)
  );

  ee_prog_timer #(.CYCLES(PROG_CYCLES)) u_timer (
    .clk_i, .rst_ni, .start_i(commit), .busy_o(busy)
  );

  ee_mem_array #(.AW(AW), .DW(DW)) u_mem (
    .clk_i, .we_i(commit), .waddr_i(wr_addr), .wdata_i(wr_data),
    .raddr_i(ptr), .rdata_o(mem_rdata)
  );

  assign commit = stop_det & pend_wr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st       <= ST_IDLE;
      nxt      <= NX_HOLD;
      bit_cnt  <= '0;
      sh       <= '0;
      byte_rdy <= 1'b0;
      pend_wr  <= 1'b0;
      oe_q     <= 1'b0;
      m_ack    <= 1'b0;
      ptr      <= '0;
      wr_addr  <= '0;
      wr_data  <= '0;
    end else if (start_det) begin
      st       <= ST_DEV;
      bit_cnt  <= '0;
      byte_rdy <= 1'b0;
      oe_q     <= 1'b0;
      pend_wr  <= 1'b0;
    end else if (stop_det) begin
      st       <= ST_IDLE;
      byte_rdy <= 1'b0;
      oe_q     <= 1'b0;
      pend_wr  <= 1'b0;
      if (pend_wr) ptr <= wr_addr + 1'b1;
    end else begin
      case (st)
        ST_DEV, ST_WADDR, ST_WDATA: begin
          if (scl_rise && !byte_rdy) begin
            sh      <= {sh[DW-2:0], sda_s};
            bit_cnt <= bit_cnt + 1'b1;
            if (bit_cnt == LAST_BIT) byte_rdy <= 1'b1;
          end else if (scl_fall && byte_rdy) begin
            byte_rdy <= 1'b0;
            bit_cnt  <= '0;
            case (st)
              ST_DEV: begin
                if (sh[DW-1:1] == DEV_ADDR && !busy) begin
                  oe_q <= 1'b1;
                  st   <= ST_ACK;
                  nxt  <= sh[0] ? NX_RD : NX_WADDR;
                end else begin
                  st <= ST_IDLE;
                end
              end
              ST_WADDR: begin
                ptr     <= sh;
                wr_addr <= sh;
                oe_q    <= 1'b1;
                st      <= ST_ACK;
                nxt     <= NX_WDATA;
              end
              default: begin
                wr_data <= sh;
                pend_wr <= 1'b1;
                oe_q    <= 1'b1;
                st      <= ST_ACK;
                nxt     <= NX_HOLD;
              end
            endcase
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            case (nxt)
              NX_WADDR: begin oe_q <= 1'b0; st <= ST_WADDR; end
              NX_WDATA: begin oe_q <= 1'b0; st <= ST_WDATA; end
              NX_RD: begin
                sh      <= mem_rdata;
                oe_q    <= ~mem_rdata[DW-1];
                bit_cnt <= '0;
                st      <= ST_RD;
              end
              default: begin oe_q <= 1'b0; st <= ST_IDLE; end
            endcase
          end
        end
        ST_RD: begin
          if (scl_fall) begin
            if (bit_cnt == LAST_BIT) begin
              oe_q  <= 1'b0;
              m_ack <= 1'b0;
              ptr   <= ptr + 1'b1;
              st    <= ST_RACK;
            end else begin
              bit_cnt <= bit_cnt + 1'b1;
              sh      <= {sh[DW-2:0], 1'b0};
              oe_q    <= ~sh[DW-2];
            end
          end
        end
        ST_RACK: begin
          if (scl_rise) begin
            m_ack <= ~sda_s;
          end else if (scl_fall) begin
            if (m_ack) begin
              sh      <= mem_rdata;
              oe_q    <= ~mem_rdata[DW-1];
              bit_cnt <= '0;
              st      <= ST_RD;
            end else begin
              st <= ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign sda_oe_o = oe_q;

  // R1
  oe_only_when_talking_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sda_oe_o |-> (st == ST_ACK || st == ST_RD));

  // R8
  release_on_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_det |=> !sda_oe_o);

  // R5
  busy_nack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_DEV && scl_fall && byte_rdy && busy) |=> !sda_oe_o);

  // R7
  ptr_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_RD && scl_fall && bit_cnt == LAST_BIT && ptr == '1) |=> ptr == '0);
endmodule

// File: tb/i2c_eeprom_ctrl_test.sv
module i2c_eeprom_ctrl_test;
  localparam int PROG = 600;
  localparam int HALF = 8;
  localparam logic [6:0] DEV = 7'h50;
  localparam int NVEC = 6;
  // {word address, data}
  localparam logic [15:0] VEC [NVEC] = '{16'h00A5, 16'hFF3C, 16'h1000,
                                          16'h11FF, 16'h805A, 16'h7F81};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe;
  wire  sda_line = sda_m & ~sda_oe;
  int   n_chk = 0, n_bad = 0;
  bit   done = 1'b0;

  always #2 clk = ~clk;

  i2c_eeprom_ctrl #(.DEV_ADDR(DEV), .PROG_CYCLES(PROG)) uut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe_o(sda_oe)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wt();
    repeat (HALF) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wt(); scl_m = 1'b1; wt(); sda_m = 1'b0; wt(); scl_m = 1'b0; wt();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wt(); scl_m = 1'b1; wt(); sda_m = 1'b1; wt();
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 0; i < n; i++) begin
      sda_m = b[7-i]; wt(); scl_m = 1'b1; wt(); scl_m = 1'b0; wt();
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    send_bits(b, 8);
    sda_m = 1'b1; wt(); scl_m = 1'b1; wt();
    ack = !sda_line;
    scl_m = 1'b0; wt();
  endtask

  task automatic recv_byte(input bit mack, output logic [7:0] d);
    sda_m = 1'b1;
    d = '0;
    for (int i = 0; i < 8; i++) begin
      wt(); scl_m = 1'b1; wt(); d = {d[6:0], sda_line}; scl_m = 1'b0;
    end
    wt(); sda_m = ~mack; wt(); scl_m = 1'b1; wt(); scl_m = 1'b0; wt(); sda_m = 1'b1;
  endtask

  task automatic do_write(input logic [7:0] a, input logic [7:0] d, output bit ok);
    bit a0, a1, a2;
    bus_start();
    send_byte({DEV, 1'b0}, a0);
    send_byte(a, a1);
    send_byte(d, a2);
    bus_stop();
    ok = a0 & a1 & a2;
  endtask

  task automatic wait_ready(output int polls);
    bit ack;
    polls = 0;
    do begin
      bus_start();
      send_byte({DEV, 1'b0}, ack);
      bus_stop();
      polls++;
    end while (!ack && polls < 20);
  endtask

  task automatic rand_read(input logic [7:0] a, input bit mack, output logic [7:0] d,
                           output bit ok);
    bit a0, a1, a2;
    bus_start();
    send_byte({DEV, 1'b0}, a0);
    send_byte(a, a1);
    bus_start();
    send_byte({DEV, 1'b1}, a2);
    recv_byte(mack, d);
    ok = a0 & a1 & a2;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    bit ok, ack;
    int polls;
    logic [7:0] d, d2;

    repeat (5) @(negedge clk);
    // R1: released after reset
    chk(sda_oe == 1'b0, "R1 reset", int'(sda_oe), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    for (int v = 0; v < NVEC; v++) begin
      do_write(VEC[v][15:8], VEC[v][7:0], ok);
      chk(ok, "R4 write acks", int'(ok), 1);
      wait_ready(polls);
      // R5: first poll refused, a later one accepted
      chk(polls >= 2 && polls < 20, "R5 busy poll", polls, 2);
      rand_read(VEC[v][15:8], 1'b0, d, ok);
      bus_stop();
      chk(ok, "R3 read acks", int'(ok), 1);
      chk(d == VEC[v][7:0], "R6 read data", int'(d), int'(VEC[v][7:0]));
    end

    // R3: foreign address not acknowledged
    bus_start();
    send_byte({7'h51, 1'b0}, ack);
    bus_stop();
    chk(!ack, "R3 foreign addr", int'(ack), 0);

    // R7: sequential read across 255 -> 0, R8: release after nack
    rand_read(8'hFF, 1'b1, d, ok);
    recv_byte(1'b0, d2);
    chk(d == 8'h3C, "R7 seq first", int'(d), 'h3C);
    chk(d2 == 8'hA5, "R7 seq wrap", int'(d2), 'hA5);
    wt();
    chk(sda_oe == 1'b0, "R8 release", int'(sda_oe), 0);
    bus_stop();

    // R6: current-address read after write points to addr+1
    do_write(8'h21, 8'h6E, ok); wait_ready(polls);
    do_write(8'h20, 8'h42, ok); wait_ready(polls);
    bus_start();
    send_byte({DEV, 1'b1}, ack);
    recv_byte(1'b0, d);
    bus_stop();
    chk(ack && d == 8'h6E, "R6 current read", int'(d), 'h6E);

    // R4: second data byte refused, first stored
    bus_start();
    send_byte({DEV, 1'b0}, ack);
    send_byte(8'h30, ack);
    send_byte(8'h11, ack);
    send_byte(8'h22, ack);
    bus_stop();
    chk(!ack, "R4 extra byte nack", int'(ack), 0);
    wait_ready(polls);
    rand_read(8'h30, 1'b0, d, ok);
    bus_stop();
    chk(d == 8'h11, "R4 first byte kept", int'(d), 'h11);

    // R9: stop inside data byte -> nothing stored, not busy
    bus_start();
    send_byte({DEV, 1'b0}, ack);
    send_byte(8'h10, ack);
    send_bits(8'hEE, 4);
    bus_stop();
    bus_start();
    send_byte({DEV, 1'b0}, ack);
    bus_stop();
    chk(ack, "R9 not busy after abort", int'(ack), 1);
    rand_read(8'h10, 1'b0, d, ok);
    bus_stop();
    chk(d == 8'h00, "R9 no store", int'(d), 0);

    // R9/R2: start inside address byte restarts device address reception
    bus_start();
    send_bits(8'h55, 5);
    bus_start();
    send_byte({DEV, 1'b1}, ack);
    recv_byte(1'b0, d);
    bus_stop();
    chk(ack, "R2 restart ack", int'(ack), 1);
    chk(d == 8'hFF, "R9 restart read", int'(d), 'hFF);
    wt();
    chk(sda_oe == 1'b0, "R1 idle release", int'(sda_oe), 0);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule